// File: doc/BRIEF.md
# Radix-4 Carry-Save Digit-Recurrence Divider

This block divides a fixed-point dividend by a normalized divisor. It produces two quotient bits per clock cycle. Each step picks a signed digit from {-2,-1,0,+1,+2}. The partial remainder is held as a redundant sum/carry pair, so no step waits for a full-width carry chain. A small estimator adds only the top eight bits of the shifted sum and carry. It compares the result against constant thresholds chosen by four fraction bits of the divisor. The chosen digit selects one of five multiples: zero, the divisor, or its shifted double, either added or subtracted.

Both operands are W-bit unsigned values with W-1 fraction bits. The divisor must have its most significant bit set, so it lies in [1,2). The dividend may be any W-bit value. Positive and negative digits are collected in two separate shift registers. One subtraction at the end, together with a sign check of the final remainder, produces the binary quotient.

A division is offered with `start_valid`. It is taken on the rising clock edge where `start_ready` is also high. `start_ready` stays low for the whole computation, which is the only back-pressure on the input. The result port has no back-pressure: `done` pulses for one cycle, and `quotient` holds its value until the next division completes.

Top module: `srt4_divider`

## Requirements
- R1: While reset is applied and immediately after it, `busy` and `done` are 0, `start_ready` is 1 and `quotient` is 0.
- R2: `start_ready` is high exactly when no division is in progress. Operands are captured only on an edge where `start_valid` and `start_ready` are both high. A request held while busy is ignored and does not alter the running result.
- R3: For a divisor whose most significant bit is 1, `quotient` equals floor(dividend · 4^(NDIG-1) / divisor), with both operands read as integers.
- R4: `busy` is high from the accepting edge onward. `done` is a single-cycle pulse raised by the edge NDIG+1 cycles after the accepting edge, and `busy` falls on that same edge.
- R5: After every step, the carry-save partial remainder R satisfies |R| ≤ (2/3)·D. Here R and D use the same fixed-point scale, and the initial remainder is the dividend divided by 4.
- R6: Once `done` has pulsed, `quotient` keeps its value until the next division finishes.
- R7: Boundary cases hold. A zero dividend gives 0. A dividend equal to the divisor gives 4^(NDIG-1). The largest dividend with the smallest divisor gives the largest quotient, which is below 2^(2·NDIG-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Request to begin a division with the present operands |
| start_ready | output | 1 | High when a request can be taken |
| dividend | input | W | Unsigned dividend, W-1 fraction bits |
| divisor | input | W | Unsigned divisor, W-1 fraction bits, MSB must be 1 |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse when the quotient is valid |
| quotient | output | 2·NDIG | Binary quotient, held between divisions |

## Verification
Directed operands cover the extremes of the digit table:
- A zero dividend keeps every digit at zero.
- Equal operands give a single leading +1 followed by zeros.
- A dividend one below the divisor forces a negative final remainder, so the end correction must fire.
- The largest dividend over the smallest divisor drives the remainder toward its bound and uses the +2 multiple.

Random operands with a forced divisor MSB then mix digit signs freely, which separates errors in the ±2D path from errors in the ±D path. A request held while busy shows whether operands leak into a running division.

// File: rtl/srt4_pkg.sv
package srt4_pkg;

  // Signed quotient digit: magnitude 0..2 plus a sign flag (zero is never negative)
  typedef struct packed {
    logic       neg;
    logic [1:0] mag;
  } sdigit_t;

  // Number of divisor fraction bits examined and estimate width
  localparam int SEL_DBITS = 4;
  localparam int SEL_CELLS = 1 << SEL_DBITS;
  localparam int SEL_EBITS = 8;

  // Lowest estimate (units of 1/4) for which digit k is chosen in divisor cell didx.
  // Threshold = ceil(4 * (k - 2/3) * Dworst), Dworst the cell edge that binds.
  function automatic int sel_threshold(input int k, input int didx);
    int dw;
    int a;
    int r;
    dw = SEL_CELLS + didx + ((k >= 1) ? 1 : 0);
    a  = (12 * k - 8) * dw;
    if (a >= 0) r = (a + 47) / 48;
    else        r = -((-a) / 48);
    return r;
  endfunction

endpackage

// File: rtl/srt4_qsel.sv
module srt4_qsel
  import srt4_pkg::*;
(
  input  logic [SEL_EBITS-1:0] s_hi,
  input  logic [SEL_EBITS-1:0] c_hi,
  input  logic [SEL_DBITS-1:0] dfrac,
  output sdigit_t              q
);
  // Short carry-propagated estimate: 4 integer bits, 4 fraction bits
  logic signed [SEL_EBITS-1:0] est;
  int                          e;
  assign est = s_hi + c_hi;
  assign e   = int'(est);

  logic [SEL_CELLS-1:0] ge_p2, ge_p1, ge_z, ge_m1;

  for (genvar g = 0; g < SEL_CELLS; g++) begin : g_cell
    // thresholds scaled to the 1/16 estimate grid (their low bits are zero)
    localparam int T_P2 = 4 * sel_threshold(2, g);
    localparam int T_P1 = 4 * sel_threshold(1, g);
    localparam int T_Z  = 4 * sel_threshold(0, g);
    localparam int T_M1 = 4 * sel_threshold(-1, g);
    assign ge_p2[g] = (e >= T_P2);
    assign ge_p1[g] = (e >= T_P1);
    assign ge_z[g]  = (e >= T_Z);
    assign ge_m1[g] = (e >= T_M1);
  end

  always_comb begin
    if (ge_p2[dfrac])      q = '{neg: 1'b0, mag: 2'd2};
    else if (ge_p1[dfrac]) q = '{neg: 1'b0, mag: 2'd1};
    else if (ge_z[dfrac])  q = '{neg: 1'b0, mag: 2'd0};
    else if (ge_m1[dfrac]) q = '{neg: 1'b1, mag: 2'd1};
    else                   q = '{neg: 1'b1, mag: 2'd2};
  end
endmodule

// File: rtl/srt4_step.sv
module srt4_step
  import srt4_pkg::*;
#(
  parameter int RW = 21
) (
  input  logic [RW-1:0] s4,
  input  logic [RW-1:0] c4,
  input  logic [RW-1:0] dmul,
  input  sdigit_t       q,
  output logic [RW-1:0] ns,
  output logic [RW-1:0] nc
);
  logic [RW-1:0] mult;
  logic [RW-1:0] addend;
  logic [RW-1:0] maj;
  logic          sub;

  always_comb begin
    case (q.mag)
      2'd1:    mult = dmul;
      2'd2:    mult = dmul << 1;
      default: mult = '0;
    endcase
  end

  // positive digit subtracts: invert here, the +1 enters the free carry LSB
  assign sub    = !q.neg && (q.mag != 2'd0);
  assign addend = sub ? ~mult : mult;

  for (genvar b = 0; b < RW; b++) begin : g_fa
    assign ns[b]  = s4[b] ^ c4[b] ^ addend[b];
    assign maj[b] = (s4[b] & c4[b]) | (s4[b] & addend[b]) | (c4[b] & addend[b]);
  end

  assign nc = (maj << 1) | RW'(sub);
endmodule

// File: rtl/srt4_qacc.sv
module srt4_qacc
  import srt4_pkg::*;
#(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  sdigit_t       q,
  output logic [QW-1:0] pos,
  output logic [QW-1:0] neg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      neg <= '0;
    end else if (clr) begin
      pos <= '0;
      neg <= '0;
    end else if (en) begin
      pos <= (pos << 2) | QW'(q.neg ? 2'd0 : q.mag);
      neg <= (neg << 2) | QW'(q.neg ? q.mag : 2'd0);
    end
  end
endmodule

// File: rtl/srt4_divider.sv
module srt4_divider
  import srt4_pkg::*;
#(
  parameter int W    = 16,
  parameter int NDIG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [W-1:0]      dividend,
  input  logic [W-1:0]      divisor,
  output logic              busy,
  output logic              done,
  output logic [2*NDIG-1:0] quotient
);
  localparam int RW = W + 5;             // 4 integer bits, W+1 fraction bits
  localparam int QW = 2 * NDIG;
  localparam int CW = $clog2(NDIG + 1);
  localparam logic [RW-1:0] SIGN_MIN = {1'b1, {(RW-1){1'b0}}};

  typedef enum logic [1:0] {ST_IDLE, ST_ITER, ST_FIX} st_t;

  st_t           state;
  logic [RW-1:0] sum_q, carry_q;
  logic [W-1:0]  div_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] s4, c4, dmul, ns, nc;
  logic [QW-1:0] qpos, qneg;
  sdigit_t       dig;
  logic          accept, rneg, iter;

  assign start_ready = (state == ST_IDLE);
  assign busy        = (state != ST_IDLE);
  assign accept      = start_valid && start_ready;
  assign iter        = (state == ST_ITER);

  assign s4   = {sum_q[RW-3:0], 2'b00};
  assign c4   = {carry_q[RW-3:0], 2'b00};
  assign dmul = {3'b000, div_q, 2'b00};
  assign rneg = (sum_q + carry_q) >= SIGN_MIN;

  srt4_qsel u_qsel (
    .s_hi  (s4[RW-1 -: SEL_EBITS]),
    .c_hi  (c4[RW-1 -: SEL_EBITS]),
    .dfrac (div_q[W-2 -: SEL_DBITS]),
    .q     (dig)
  );

  srt4_step #(.RW(RW)) u_step (
    .s4   (s4),
    .c4   (c4),
    .dmul (dmul),
    .q    (dig),
    .ns   (ns),
    .nc   (nc)
  );

  srt4_qacc #(.QW(QW)) u_qacc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (iter),
    .q     (dig),
    .pos   (qpos),
    .neg   (qneg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sum_q    <= '0;
      carry_q  <= '0;
      div_q    <= '0;
      cnt_q    <= '0;
      done     <= 1'b0;
      quotient <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            sum_q   <= RW'(dividend);    // dividend/4 on the remainder scale
            carry_q <= '0;
            div_q   <= divisor;
            cnt_q   <= '0;
            state   <= ST_ITER;
          end
        end
        ST_ITER: begin
          sum_q   <= ns;
          carry_q <= nc;
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == CW'(NDIG - 1)) state <= ST_FIX;
        end
        ST_FIX: begin
          quotient <= qpos - qneg - QW'(rneg);
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srt4_divider_chk.sv
module srt4_divider_chk #(
  parameter int W    = 16,
  parameter int NDIG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic              busy,
  input logic              done,
  input logic [2*NDIG-1:0] quotient,
  input logic [W+4:0]      st_sum,
  input logic [W+4:0]      st_carry,
  input logic [W-1:0]      st_div
);
  localparam int RW = W + 5;
  localparam int LW = $clog2(NDIG + 3);

  logic [LW-1:0]   lat;
  logic [RW-1:0]   rv;
  logic [RW+3:0]   rabs, lhs, rhs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         lat <= '0;
    else if (start_valid && start_ready) lat <= '0;
    else if (busy)                      lat <= lat + 1'b1;
  end

  assign rv   = st_sum + st_carry;
  assign rabs = rv[RW-1] ? {4'b0000, (~rv + 1'b1)} : {4'b0000, rv};
  assign lhs  = rabs + (rabs << 1);
  assign rhs  = (RW+4)'(st_div) << 3;

  // R5
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lhs <= rhs));

  // R4
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == LW'(NDIG + 1)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> busy);

  // R6
  hold_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(quotient));
endmodule

bind srt4_divider srt4_divider_chk #(.W(W), .NDIG(NDIG)) u_srt4_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .busy        (busy),
  .done        (done),
  .quotient    (quotient),
  .st_sum      (sum_q),
  .st_carry    (carry_q),
  .st_div      (div_q)
);

// File: tb/test_srt4_divider.sv
module test_srt4_divider;
  localparam int W    = 16;
  localparam int NDIG = 8;
  localparam int QW   = 2 * NDIG;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic [W-1:0]  dividend = '0;
  logic [W-1:0]  divisor = '0;
  logic          busy;
  logic          done;
  logic [QW-1:0] quotient;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  srt4_divider #(.W(W), .NDIG(NDIG)) i_srt4_divider (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .quotient    (quotient)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_q(input logic [W-1:0] x, input logic [W-1:0] d);
    return (longint'(x) << (2 * (NDIG - 1))) / longint'(d);
  endfunction

  task automatic run_div(input logic [W-1:0] x, input logic [W-1:0] d,
                         input bit poke, input string tag);
    logic [QW-1:0] exp_q;
    logic [QW-1:0] held;
    int  cyc;
    bit  seen;
    exp_q = QW'(ref_q(x, d));
    @(negedge clk);
    dividend    = x;
    divisor     = d;
    start_valid = 1'b1;
    cyc  = 0;
    seen = 0;
    while (!seen && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        check(busy && !start_ready, "R4 busy after accept", {busy, start_ready}, 2);
        if (poke) begin
          dividend = ~x;
          divisor  = {1'b1, ~d[W-2:0]};
        end else begin
          start_valid = 1'b0;
        end
      end
      if (poke && cyc == 2) check(!start_ready, "R2 ready low while busy", start_ready, 0);
      if (poke && cyc == 4) start_valid = 1'b0;
      if (done) seen = 1;
    end
    check(cyc == NDIG + 2, "R4 latency", cyc, NDIG + 2);
    check(quotient == exp_q, tag, quotient, exp_q);
    held = quotient;
    @(negedge clk);
    check(!done, "R4 done single pulse", done, 0);
    repeat (2) @(negedge clk);
    check(quotient == held, "R6 quotient held", quotient, held);
    check(start_ready && !busy, "R2 ready when idle", {start_ready, busy}, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rx;
    logic [31:0] rd;
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!busy && !done && start_ready && quotient == '0, "R1 in reset",
          {busy, done, start_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && start_ready && quotient == '0, "R1 after reset",
          quotient, 0);

    // R7 boundary cases
    run_div(16'h0000, 16'h8000, 0, "R7 zero dividend");
    run_div(16'h8000, 16'h8000, 0, "R7 equal operands");
    run_div(16'hFFFF, 16'hFFFF, 0, "R7 equal max operands");
    // R5 worst remainder: largest dividend over smallest divisor
    run_div(16'hFFFF, 16'h8000, 0, "R7 R5 max quotient");
    run_div(16'h0001, 16'hFFFF, 0, "R3 tiny dividend");
    run_div(16'h8000, 16'hFFFF, 0, "R3 small quotient");
    run_div(16'hC000, 16'hA000, 0, "R3 mid operands");
    // R2: request held while busy must not disturb the result
    run_div(16'h9ABC, 16'hC123, 1, "R2 held request ignored");
    run_div(16'h3FFF, 16'h8001, 1, "R2 held request ignored");

    for (int i = 0; i < 300; i++) begin
      rx = $urandom;
      rd = $urandom | 32'h0000_8000;
      case (i % 3)
        0: run_div(rx[W-1:0], rd[W-1:0], 0, "R3 random");
        1: run_div(rd[W-1:0] - 16'd1, rd[W-1:0], 0, "R3 R5 dividend below divisor");
        default: run_div(rd[W-1:0], rd[W-1:0], 0, "R7 R3 random equal");
      endcase
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule